// File: doc/BRIEF.md
# I2C Register Target with Mode-Dependent Write Protection

This block is a bus target for a two-wire serial bus. A bus master reaches a byte-addressed register file through it. Both bus lines are open-drain. The block samples SCL and SDA with the system clock. It pulls SDA low through an output-enable pin only while SCL is low. Every register write it accepts is also reported to the core logic as a one-cycle strobe with the register index and the data. The core logic supplies a status byte that the master can read but can never overwrite.

The block has two runtime modes. In normal mode, seven configuration registers reject writes, although the transfer is still acknowledged. One of these registers holds the block's own bus address. In setup mode, every register accepts writes except the status register and the command register. Command bytes written to the command register switch between the modes and turn the scan-enable output on or off. The block leaves reset in normal mode with scanning enabled.

Top module: `i2c_lock_target`

## Requirements
- R1: After reset, setup_mode is 0, scan_en is 1, sda_oe is 0, and the target answers bus address 0x4B, the low seven bits of register 0x07.
- R2: The first byte after any start condition is an address byte: bits 7..1 are compared with register 0x07 bits 6..0, and bit 0 selects the direction (0 master writes, 1 master reads). On a match, SDA is held low for the ninth clock.
- R3: When the address does not match, no ACK is given. SDA stays released for the rest of the transfer, and the data bytes that follow change no register.
- R4: In a write, the first data byte after the address loads the register pointer. Each later byte is written to the register at the pointer, and the pointer then advances by one, wrapping from 0xFF to 0x00. Every data byte is acknowledged.
- R5: A read returns the register at the current pointer and advances the pointer after each byte. A NACK from the master ends the read, and SDA is then released.
- R6: In normal mode, writes to registers 0x07, 0x08, 0x11, 0x50, 0x51, 0x5C and 0x5D are acknowledged but leave the register unchanged.
- R7: In setup mode, every register except 0xA0 and 0xB0 takes the written value.
- R8: Register 0xB0 reads back the core_status input and ignores writes in both modes.
- R9: A byte written to register 0xA0 is a command: 0x0A clears scan_en, 0x0B sets it, 0x0C enters setup mode, 0x0D returns to normal mode, and any other code has no effect. Reading 0xA0 gives {6'b0, scan_en, setup_mode}.
- R10: A repeated start returns the target to address-byte reception, whatever byte or bit it was in.
- R11: A new value written to register 0x07 takes effect as the bus address from the next address byte on. After that, the old address is not acknowledged.
- R12: rf_we pulses for one cycle for each accepted register write, with rf_waddr and rf_wdata holding the index and data. It does not pulse for pointer bytes, commands, or ignored writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| core_status | input | 8 | Status byte shown at register 0xB0 |
| rf_we | output | 1 | Accepted register write strobe |
| rf_waddr | output | 8 | Index of the accepted write |
| rf_wdata | output | 8 | Data of the accepted write |
| setup_mode | output | 1 | 1 while in setup mode |
| scan_en | output | 1 | Scanning enable |

## Verification
The hardest case to reach is a change of the target's own address. This can only happen in setup mode, through a write burst that passes over register 0x07. After it, every later transfer must use the new address. The bench reaches it by sweeping write bursts over the lower half of the register file, first in normal mode and then in setup mode. A bench-side model tracks the expected contents, including the address register, and the bench reads everything back under the address the model predicts. It then confirms that the old address gets no ACK. Repeated starts are placed inside write bursts and between the pointer write and the read, to exercise R10.

// File: rtl/i2c_lock_pkg.sv
package i2c_lock_pkg;
  localparam int REG_AW = 8;
  localparam int DEPTH  = 1 << REG_AW;

  localparam logic [7:0] CMD_REG     = 8'hA0;
  localparam logic [7:0] STATUS_REG  = 8'hB0;
  localparam logic [7:0] DEVADDR_REG = 8'h07;

  localparam logic [7:0] CMD_SCAN_OFF = 8'h0A;
  localparam logic [7:0] CMD_SCAN_ON  = 8'h0B;
  localparam logic [7:0] CMD_SETUP    = 8'h0C;
  localparam logic [7:0] CMD_NORMAL   = 8'h0D;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AEND, ST_ACK, ST_WDATA,
    ST_WEND, ST_RDATA, ST_RACK, ST_RNEXT, ST_IGNORE
  } link_st_t;

  // configuration registers frozen while in normal mode
  function automatic logic is_guarded(input logic [7:0] a);
    case (a)
      8'h07, 8'h08, 8'h11, 8'h50, 8'h51, 8'h5C, 8'h5D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_fixed_ro(input logic [7:0] a);
    return a == STATUS_REG;
  endfunction

  function automatic logic wr_allowed(input logic [7:0] a, input logic setup);
    return !is_fixed_ro(a) && (a != CMD_REG) && (setup || !is_guarded(a));
  endfunction
endpackage

// File: rtl/i2c_lock_sync.sv
module i2c_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // line events only count while the clock line is steady high
  assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_lock_link.sv
module i2c_lock_link
  import i2c_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_q,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_evt,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  link_st_t   st;
  logic [2:0] bitcnt;
  logic [7:0] sh;
  logic       rw, need_ptr;

  logic [7:0] byte_in;
  logic       byte_fire;
  assign byte_in   = {sh[6:0], sda_q};
  assign byte_fire = (st == ST_WDATA) && scl_rise && (bitcnt == 3'd7);
  assign wr_evt    = byte_fire && !need_ptr;
  assign wr_addr   = ptr;
  assign wr_data   = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; sh <= '0; rw <= 1'b0;
      need_ptr <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WDATA: if (scl_rise) begin
          sh     <= byte_in;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) st <= (st == ST_ADDR) ? ST_AEND : ST_WEND;
          if (byte_fire) begin
            if (need_ptr) begin ptr <= byte_in; need_ptr <= 1'b0; end
            else ptr <= ptr + 8'd1;
          end
        end
        ST_AEND: if (scl_fall) begin
          if (sh[7:1] == dev_addr) begin
            st <= ST_ACK; sda_oe <= 1'b1; rw <= sh[0]; need_ptr <= ~sh[0];
          end else st <= ST_IGNORE;
        end
        ST_WEND: if (scl_fall) begin st <= ST_ACK; sda_oe <= 1'b1; end
        ST_ACK, ST_RNEXT: if (scl_fall) begin
          bitcnt <= '0;
          if (st == ST_RNEXT || rw) begin
            st <= ST_RDATA; sh <= rd_data; sda_oe <= ~rd_data[7];
          end else begin
            st <= ST_WDATA; sda_oe <= 1'b0;
          end
        end
        ST_RDATA: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            st <= ST_RACK; sda_oe <= 1'b0; ptr <= ptr + 8'd1; bitcnt <= '0;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; bitcnt <= bitcnt + 3'd1;
          end
        end
        ST_RACK: if (scl_rise) st <= sda_q ? ST_IGNORE : ST_RNEXT;
        default: ;
      endcase
    end
  end

  a_r3_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);
  a_r2_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));
  a_r10_restart_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR) && (bitcnt == 3'd0));
  a_r5_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && scl_rise && sda_q && !start_evt && !stop_evt) |=> !sda_oe);
endmodule

// File: rtl/i2c_lock_regs.sv
module i2c_lock_regs
  import i2c_lock_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_RST = 7'h4B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_evt,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  input  logic [7:0] core_status,
  output logic [7:0] rd_data,
  output logic [6:0] dev_addr,
  output logic       setup_mode,
  output logic       scan_en,
  output logic       rf_we,
  output logic [7:0] rf_waddr,
  output logic [7:0] rf_wdata
);
  logic [7:0] mem [DEPTH];
  logic accept, cmd_hit;

  assign accept  = wr_evt && wr_allowed(wr_addr, setup_mode);
  assign cmd_hit = wr_evt && (wr_addr == CMD_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (8'(i) == DEVADDR_REG) ? {1'b0, DEV_ADDR_RST} : 8'h00;
      setup_mode <= 1'b0;
      scan_en    <= 1'b1;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
    end else begin
      rf_we <= accept;
      if (accept) begin
        mem[wr_addr] <= wr_data;
        rf_waddr     <= wr_addr;
        rf_wdata     <= wr_data;
      end
      if (cmd_hit) begin
        case (wr_data)
          CMD_SCAN_OFF: scan_en    <= 1'b0;
          CMD_SCAN_ON:  scan_en    <= 1'b1;
          CMD_SETUP:    setup_mode <= 1'b1;
          CMD_NORMAL:   setup_mode <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (rd_addr == CMD_REG)         rd_data = {6'b0, scan_en, setup_mode};
    else if (rd_addr == STATUS_REG) rd_data = core_status;
    else                            rd_data = mem[rd_addr];
  end
  assign dev_addr = mem[DEVADDR_REG][6:0];

  a_r6_addr_reg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !setup_mode && wr_addr == DEVADDR_REG) |=> $stable(dev_addr));
  a_r8_status_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != STATUS_REG));
  a_r9_scan_off_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_addr == CMD_REG && wr_data == CMD_SCAN_OFF) |=> !scan_en);
  a_r9_mode_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setup_mode) |-> $past(wr_evt && wr_addr == CMD_REG));
  a_r12_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(wr_evt));
endmodule

// File: rtl/i2c_lock_target.sv
module i2c_lock_target #(
  parameter int         SYNC_STAGES  = 2,
  parameter logic [6:0] DEV_ADDR_RST = 7'h4B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] core_status,
  output logic       rf_we,
  output logic [7:0] rf_waddr,
  output logic [7:0] rf_wdata,
  output logic       setup_mode,
  output logic       scan_en
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic [6:0] dev_addr;
  logic [7:0] rd_data, ptr, wr_addr, wr_data;
  logic       wr_evt;

  i2c_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_q, .sda_q,
    .scl_rise, .scl_fall, .start_evt, .stop_evt
  );

  i2c_lock_link u_link (
    .clk, .rst_n, .scl_q, .sda_q, .scl_rise, .scl_fall, .start_evt, .stop_evt,
    .dev_addr, .rd_data, .sda_oe, .ptr, .wr_evt, .wr_addr, .wr_data
  );

  i2c_lock_regs #(.DEV_ADDR_RST(DEV_ADDR_RST)) u_regs (
    .clk, .rst_n, .wr_evt, .wr_addr, .wr_data, .rd_addr(ptr), .core_status,
    .rd_data, .dev_addr, .setup_mode, .scan_en, .rf_we, .rf_waddr, .rf_wdata
  );
endmodule

// File: tb/tb_i2c_lock_target.sv
module tb_i2c_lock_target;
  localparam int CLK_P = 10;
  localparam int Q     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] core_status = 8'h5A;
  logic sda_oe, setup_mode, scan_en, rf_we;
  logic [7:0] rf_waddr, rf_wdata;
  wire  sda_line = sda_m & ~sda_oe;

  i2c_lock_target dut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_oe, .core_status,
    .rf_we, .rf_waddr, .rf_wdata, .setup_mode, .scan_en
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, we_cnt = 0;
  always @(posedge clk) if (rf_we) we_cnt <= we_cnt + 1;

  logic [7:0] exp_mem [256];
  logic exp_setup = 1'b0, exp_scan = 1'b1;

  function automatic logic guarded(input logic [7:0] a);
    return a inside {8'h5D, 8'h5C, 8'h51, 8'h50, 8'h11, 8'h08, 8'h07};
  endfunction
  function automatic logic [6:0] dev();
    return exp_mem[7][6:0];
  endfunction
  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'hA0) return {6'b0, exp_scan, exp_setup};
    if (a == 8'hB0) return core_status;
    return exp_mem[a];
  endfunction
  function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hA0) begin
      if (d == 8'h0A) exp_scan = 1'b0;
      if (d == 8'h0B) exp_scan = 1'b1;
      if (d == 8'h0C) exp_setup = 1'b1;
      if (d == 8'h0D) exp_setup = 1'b0;
    end else if (a != 8'hB0 && (exp_setup || !guarded(a))) exp_mem[a] = d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask
  task automatic bus_rstart;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask
  task automatic bus_stop;
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask
  task automatic bit_out(input logic b, output logic seen);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); seen = sda_line; tick(Q); scl_m = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i], s);
    bit_out(1'b1, s);
    acked = !s;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_out(1'b1, s); b[i] = s; end
    bit_out(!give_ack, s);
  endtask

  // burst write: register r gets (r*mul+add) mod 256
  task automatic wr_regs(input logic [6:0] da, input logic [7:0] first, input int n,
                         input int mul, input int add, input string req);
    logic ak; int nacks; logic [7:0] r, d;
    nacks = 0;
    bus_start;
    send_byte({da, 1'b0}, ak); if (!ak) nacks++;
    send_byte(first, ak);      if (!ak) nacks++;
    for (int i = 0; i < n; i++) begin
      r = 8'(first + i); d = 8'(r * mul + add);
      send_byte(d, ak); if (!ak) nacks++;
      model_write(r, d);
    end
    bus_stop;
    check(req, nacks, 0);
  endtask
  task automatic wr1(input logic [7:0] r, input logic [7:0] d, input string req);
    logic ak; logic [6:0] da;
    da = dev();
    bus_start; send_byte({da, 1'b0}, ak); send_byte(r, ak); send_byte(d, ak);
    bus_stop;
    model_write(r, d);
    check(req, ak, 1);
  endtask
  task automatic rd_regs(input logic [7:0] first, input int n, input string req);
    logic ak; logic [7:0] b; logic [6:0] da;
    da = dev();
    bus_start; send_byte({da, 1'b0}, ak); send_byte(first, ak);
    bus_rstart; send_byte({da, 1'b1}, ak);
    check({req, " R10 ack after restart"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(req, b, exp_read(8'(first + i)));
    end
    check("R5 released after nack", sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ak; logic [7:0] b; int w0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    exp_mem[7] = 8'h4B;
    tick(5); rst_n = 1'b1; tick(5);

    check("R1 setup_mode", setup_mode, 0);
    check("R1 scan_en", scan_en, 1);
    check("R1 sda_oe", sda_oe, 0);
    rd_regs(8'hA0, 1, "R1 R9 mode readback");

    // normal-mode sweep: guarded registers must survive
    w0 = we_cnt;
    wr_regs(dev(), 8'h00, 128, 37, 5, "R4 R2 normal sweep acks");
    check("R12 R6 strobe count normal", we_cnt - w0, 121);
    rd_regs(8'h00, 128, "R4 R5 R6 normal readback");

    // foreign address is ignored
    w0 = we_cnt;
    bus_start; send_byte({7'h22, 1'b0}, ak);
    check("R3 no ack on foreign address", ak, 0);
    send_byte(8'h10, ak); check("R3 data not acked", ak, 0);
    send_byte(8'h99, ak);
    bus_rstart; send_byte({dev(), 1'b1}, ak);
    check("R10 restart after ignore acks", ak, 1);
    recv_byte(1'b0, b); bus_stop;
    check("R3 no strobe", we_cnt - w0, 0);
    rd_regs(8'h10, 1, "R3 register unchanged");

    // status register mirrors core input
    rd_regs(8'hB0, 1, "R8 status read");
    core_status = 8'hC3;
    rd_regs(8'hAF, 3, "R8 status follows input");
    w0 = we_cnt;
    wr1(8'hB0, 8'hFF, "R8 write acked");
    check("R8 no strobe normal", we_cnt - w0, 0);

    // setup mode
    wr1(8'hA0, 8'h0C, "R9 setup cmd");
    check("R9 setup_mode set", setup_mode, 1);
    w0 = we_cnt;
    wr1(8'hB0, 8'h11, "R8 write acked setup");
    check("R8 no strobe setup", we_cnt - w0, 0);
    rd_regs(8'hB0, 1, "R8 status intact setup");
    w0 = we_cnt;
    wr_regs(dev(), 8'h00, 128, 53, 11, "R7 setup sweep acks");
    check("R7 R12 strobe count setup", we_cnt - w0, 128);
    check("R12 last waddr", rf_waddr, 8'h7F);
    check("R12 last wdata", rf_wdata, 8'(127 * 53 + 11));
    check("R11 model address moved", dev(), 7'h7E);
    rd_regs(8'h00, 128, "R7 R11 setup readback");
    bus_start; send_byte({7'h4B, 1'b0}, ak); bus_stop;
    check("R11 old address not acked", ak, 0);

    // commands
    wr1(8'hA0, 8'h0A, "R9 scan off");
    check("R9 scan_en cleared", scan_en, 0);
    wr1(8'hA0, 8'h55, "R9 unknown code");
    check("R9 unknown keeps scan", scan_en, 0);
    check("R9 unknown keeps mode", setup_mode, 1);
    wr1(8'hA0, 8'h0B, "R9 scan on");
    check("R9 scan_en set", scan_en, 1);
    wr1(8'hA0, 8'h0D, "R9 normal cmd");
    check("R9 setup_mode cleared", setup_mode, 0);
    rd_regs(8'hA0, 1, "R9 mode readback normal");
    w0 = we_cnt;
    wr1(8'h50, 8'hEE, "R6 guarded write acked");
    check("R6 R12 no strobe", we_cnt - w0, 0);
    rd_regs(8'h50, 2, "R6 guarded value kept");

    // repeated start inside a write burst
    bus_start; send_byte({dev(), 1'b0}, ak); send_byte(8'h20, ak); send_byte(8'hA5, ak);
    model_write(8'h20, 8'hA5);
    bus_rstart; send_byte({dev(), 1'b0}, ak);
    check("R10 address after restart", ak, 1);
    send_byte(8'h30, ak); send_byte(8'h3C, ak); model_write(8'h30, 8'h3C);
    bus_stop;
    rd_regs(8'h20, 2, "R10 R4 first burst part");
    rd_regs(8'h30, 1, "R10 pointer reloaded");

    // read continues from the pointer left by the last transfer
    rd_regs(8'h40, 1, "R5 set pointer");
    bus_start; send_byte({dev(), 1'b1}, ak);
    recv_byte(1'b1, b); check("R5 continues at pointer", b, exp_read(8'h41));
    recv_byte(1'b0, b); check("R5 increments", b, exp_read(8'h42));
    bus_stop;

    // pointer wrap
    wr1(8'hA0, 8'h0C, "R9 setup again");
    bus_start; send_byte({dev(), 1'b0}, ak); send_byte(8'hFF, ak);
    send_byte(8'h77, ak); send_byte(8'h66, ak); bus_stop;
    model_write(8'hFF, 8'h77); model_write(8'h00, 8'h66);
    rd_regs(8'hFF, 2, "R4 pointer wraps");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule